// File: doc/BRIEF.md
# Tick Counter With Compare Interrupts

This block keeps a 32-bit count that advances by one on each pulse of a 32768 Hz tick strobe, which arrives synchronous to the system clock. Software reaches it through a simple synchronous word-wide register port. Through that port it can:

- set the count to any value;
- read the count back;
- program three compare values;
- acknowledge the per-compare status bits that drive one shared interrupt line.

Two bits of a control word gate everything: a counter-enable bit and an oscillator-enable bit. The counter works only while both are set. While it is off, the count is frozen and reads back as zero. Writes that load the count or the compares are also dropped.

A compare fires when the count arrives at its value, either through a tick or through a load, while the counter is enabled. Turning the counter off suppresses every compare. Turning it back on lets all three act again on their stored values, counting on from the frozen count.

Top module: `tick_cmp_timer`

## Requirements
- R1: While enabled, each tickStb pulse sampled at a clock edge adds one to the count, and 0xFFFFFFFF wraps to 0.
- R2: The counter is enabled only when both bit 13 and bit 8 of the control word at offset 0x40 are 1. The whole control word reads back as written.
- R3: A write to offset 0x64 sets the count to the written data, but only while enabled; otherwise the write is dropped. A load in the same cycle as a tick wins over the increment.
- R4: A read of offset 0x68 returns the count while enabled, and 0 while disabled.
- R5: The compare values sit at offsets 0x6C, 0x70 and 0x74 (compare 0, 1, 2) and read back. Writes to them are dropped unless the counter is enabled.
- R6: Status bit i at offset 0x78 (bits 2:0) is set one clock after the count, while enabled, becomes equal to compare i, whether by a tick or by a load.
- R7: No status bit is set while disabled. After re-enable, all three compares match again against their stored values.
- R8: Reset clears the control word, all three compares, the status bits and the count.
- R9: Offsets with no readable register read as 0, and this includes the load offset 0x64. Writes to unused offsets change nothing.
- R10: While disabled, the count is held. On re-enable it resumes from the held value.
- R11: irqOut is the OR of the status bits. Writing 1 to a status bit clears it, and writing 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| tickStb | input | 1 | One-cycle 32768 Hz tick pulse |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 8 | Register byte offset |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Read data for regAddr, combinational |
| irqOut | output | 1 | Shared compare interrupt |

## Verification
The bench drives the count through a compare value while the oscillator bit alone is cleared. A design that kept matching while disabled would set a status bit there, and one that did not freeze the count would read back a wrong value after re-enable.

It writes loads and compares while the counter is disabled. A design that lets those writes through shows the new values on a later read.

It also covers these cases:

- A load that lands exactly on a compare value, which must fire like a tick does.
- A load and a tick in the same cycle, where the load must win.
- Wrap-around from all ones.
- Writing 0 to the status word, which must not acknowledge anything.

// File: rtl/tick_cmp_pkg.sv
`timescale 1ns/1ps
package tick_cmp_pkg;
  localparam int CMP_COUNT    = 3;
  localparam int CTRL_CNT_BIT = 13;
  localparam int CTRL_OSC_BIT = 8;
  localparam int OFF_CTRL     = 'h40;
  localparam int OFF_LOAD     = 'h64;
  localparam int OFF_COUNT    = 'h68;
  localparam int OFF_CMP_BASE = 'h6C;
  localparam int OFF_STATUS   = 'h78;

  typedef struct packed {
    logic                 cntEn;
    logic                 tickInc;
    logic                 loadStb;
    logic [CMP_COUNT-1:0] cmpWr;
  } dpStrobes_t;
endpackage

// File: rtl/tick_cmp_dp.sv
`timescale 1ns/1ps
module tick_cmp_dp
  import tick_cmp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        strb,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] cntVal,
  output logic [DATA_W-1:0] cmpVal [CMP_COUNT],
  output logic [CMP_COUNT-1:0] hitVec
);
  logic cntMoved;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntVal   <= '0;
      cntMoved <= 1'b0;
    end else begin
      cntMoved <= strb.loadStb | (strb.cntEn & strb.tickInc);
      if (strb.loadStb)
        cntVal <= wrData;
      else if (strb.cntEn && strb.tickInc)
        cntVal <= cntVal + DATA_W'(1);
    end
  end

  for (genvar i = 0; i < CMP_COUNT; i++) begin : g_cmp
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        cmpVal[i] <= '0;
      else if (strb.cmpWr[i])
        cmpVal[i] <= wrData;
    end
    assign hitVec[i] = cntMoved & strb.cntEn & (cntVal == cmpVal[i]);
  end

  assert_tick_inc_R1: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cntEn && strb.tickInc && !strb.loadStb) |=> cntVal == $past(cntVal) + DATA_W'(1));
  assert_load_value_R3: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadStb |=> cntVal == $past(wrData));
  assert_hold_when_off_R10: assert property (@(posedge clk) disable iff (!rstN)
    !strb.cntEn |=> $stable(cntVal));
endmodule

// File: rtl/tick_cmp_ctrl.sv
`timescale 1ns/1ps
module tick_cmp_ctrl
  import tick_cmp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 tickStb,
  input  logic                 regWrEn,
  input  logic [ADDR_W-1:0]    regAddr,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic [DATA_W-1:0]    cntVal,
  input  logic [DATA_W-1:0]    cmpVal [CMP_COUNT],
  input  logic [CMP_COUNT-1:0] hitVec,
  output dpStrobes_t           strb,
  output logic [DATA_W-1:0]    regRdData,
  output logic                 irqOut
);
  logic [DATA_W-1:0]    ctrlReg;
  logic [CMP_COUNT-1:0] status;
  logic [CMP_COUNT-1:0] clrMask;
  logic                 enabled;
  logic                 selCtrl, selLoad, selCount, selStatus;
  logic [CMP_COUNT-1:0] selCmp;

  assign enabled   = ctrlReg[CTRL_CNT_BIT] & ctrlReg[CTRL_OSC_BIT];
  assign selCtrl   = regAddr == ADDR_W'(OFF_CTRL);
  assign selLoad   = regAddr == ADDR_W'(OFF_LOAD);
  assign selCount  = regAddr == ADDR_W'(OFF_COUNT);
  assign selStatus = regAddr == ADDR_W'(OFF_STATUS);

  for (genvar i = 0; i < CMP_COUNT; i++) begin : g_dec
    assign selCmp[i]     = regAddr == ADDR_W'(OFF_CMP_BASE + 4 * i);
    assign strb.cmpWr[i] = regWrEn & selCmp[i] & enabled;
  end

  assign strb.cntEn   = enabled;
  assign strb.tickInc = tickStb;
  assign strb.loadStb = regWrEn & selLoad & enabled;
  assign clrMask      = (regWrEn && selStatus) ? regWrData[CMP_COUNT-1:0] : '0;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg <= '0;
      status  <= '0;
    end else begin
      if (regWrEn && selCtrl) ctrlReg <= regWrData;
      status <= (status & ~clrMask) | hitVec;
    end
  end

  assign irqOut = |status;

  always_comb begin
    regRdData = '0;
    if (selCtrl) regRdData = ctrlReg;
    if (selCount && enabled) regRdData = cntVal;
    if (selStatus) regRdData[CMP_COUNT-1:0] = status;
    for (int i = 0; i < CMP_COUNT; i++)
      if (selCmp[i]) regRdData = cmpVal[i];
  end

  assert_hit_raises_irq_R6: assert property (@(posedge clk) disable iff (!rstN)
    (|hitVec) |=> irqOut);
  assert_no_set_when_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    !enabled |=> (status & ~$past(status)) == '0);
  assert_count_read_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    (selCount && !enabled) |-> regRdData == '0);
  assert_irq_drops_R11: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && selStatus && (regWrData[CMP_COUNT-1:0] == '1) && hitVec == '0) |=> !irqOut);
endmodule

// File: rtl/tick_cmp_timer.sv
`timescale 1ns/1ps
module tick_cmp_timer
  import tick_cmp_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickStb,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              irqOut
);
  dpStrobes_t           strb;
  logic [DATA_W-1:0]    cntVal;
  logic [DATA_W-1:0]    cmpVal [CMP_COUNT];
  logic [CMP_COUNT-1:0] hitVec;

  tick_cmp_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickStb(tickStb), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .cntVal(cntVal),
    .cmpVal(cmpVal), .hitVec(hitVec), .strb(strb),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  tick_cmp_dp #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wrData(regWrData),
    .cntVal(cntVal), .cmpVal(cmpVal), .hitVec(hitVec)
  );
endmodule

// File: tb/tick_cmp_timer_bench.sv
`timescale 1ns/1ps
module tick_cmp_timer_bench;
  localparam logic [7:0] A_CTRL = 8'h40, A_LOAD = 8'h64, A_CNT = 8'h68,
                         A_CMP0 = 8'h6C, A_CMP1 = 8'h70, A_CMP2 = 8'h74,
                         A_STAT = 8'h78, A_FREE = 8'h50;
  localparam logic [31:0] EN_BOTH = 32'h2100, EN_CNT_ONLY = 32'h2000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        tickStb = 1'b0;
  logic        regWrEn = 1'b0;
  logic [7:0]  regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        irqOut;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  typedef struct {
    bit          isIrq;
    logic [31:0] exp;
    string       tag;
  } expItem_t;
  expItem_t expQ[$];

  always #4 clk = ~clk;

  tick_cmp_timer u_tick_cmp_timer (
    .clk(clk), .rstN(rstN), .tickStb(tickStb), .regWrEn(regWrEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .irqOut(irqOut)
  );

  // monitor: compares one expected item per cycle, away from the edge
  always @(posedge clk) begin
    #2;
    if (expQ.size() > 0) begin
      expItem_t it;
      logic [31:0] got;
      it = expQ.pop_front();
      got = it.isIrq ? {31'b0, irqOut} : regRdData;
      testsRun++;
      if (got !== it.exp) begin
        testsFailed++;
        $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
      end
    end
  end

  task automatic wrReg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); tickStb = 1'b1;
      @(negedge clk); tickStb = 1'b0;
    end
  endtask

  task automatic readChk(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    regAddr = a;
    expQ.push_back('{1'b0, e, tag});
    @(posedge clk); #3;
  endtask

  task automatic irqChk(input logic e, input string tag);
    @(negedge clk);
    expQ.push_back('{1'b1, {31'b0, e}, tag});
    @(posedge clk); #3;
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      testsRun++; testsFailed++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R8 reset state
    readChk(A_CTRL, 32'h0, "R8 ctrl");
    readChk(A_CMP0, 32'h0, "R8 cmp0");
    readChk(A_STAT, 32'h0, "R8 status");
    irqChk(1'b0, "R8 irq");
    // writes while disabled are dropped
    wrReg(A_CMP0, 32'h5);
    wrReg(A_LOAD, 32'h10);
    wrReg(A_CTRL, EN_CNT_ONLY);
    tick(2);
    readChk(A_CNT, 32'h0, "R4 read while osc bit clear");
    wrReg(A_CTRL, EN_BOTH);
    readChk(A_CTRL, EN_BOTH, "R2 ctrl readback");
    readChk(A_CNT, 32'h0, "R3 R10 load and ticks dropped while off");
    readChk(A_CMP0, 32'h0, "R5 cmp write dropped while off");
    tick(3);
    readChk(A_CNT, 32'h3, "R1 three ticks");
    wrReg(A_LOAD, 32'h100);
    readChk(A_CNT, 32'h100, "R3 load");
    wrReg(A_CMP0, 32'h102);
    wrReg(A_CMP1, 32'h104);
    readChk(A_CMP1, 32'h104, "R5 cmp1 readback");
    tick(1);
    readChk(A_STAT, 32'h0, "R6 no early match");
    tick(1);
    readChk(A_STAT, 32'h1, "R6 compare 0 match");
    irqChk(1'b1, "R11 irq from status");
    wrReg(A_STAT, 32'h0);
    readChk(A_STAT, 32'h1, "R11 zero write keeps status");
    wrReg(A_STAT, 32'h1);
    readChk(A_STAT, 32'h0, "R11 w1c clears");
    irqChk(1'b0, "R11 irq drops");
    // disable via oscillator bit
    wrReg(A_CTRL, EN_CNT_ONLY);
    tick(2);
    readChk(A_STAT, 32'h0, "R7 no match while off");
    wrReg(A_CMP2, 32'h55);
    wrReg(A_CTRL, EN_BOTH);
    readChk(A_CMP2, 32'h0, "R5 cmp2 write dropped");
    readChk(A_CNT, 32'h102, "R10 count held");
    tick(2);
    readChk(A_STAT, 32'h2, "R7 compare 1 re-armed");
    wrReg(A_STAT, 32'h7);
    wrReg(A_CMP2, 32'h300);
    wrReg(A_LOAD, 32'h300);
    readChk(A_STAT, 32'h4, "R6 load lands on compare 2");
    // load and tick in the same cycle
    @(negedge clk);
    regAddr = A_LOAD; regWrData = 32'h50; regWrEn = 1'b1; tickStb = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; tickStb = 1'b0;
    readChk(A_CNT, 32'h50, "R3 load wins over tick");
    wrReg(A_LOAD, 32'hFFFF_FFFF);
    tick(1);
    readChk(A_CNT, 32'h0, "R1 wrap");
    wrReg(A_FREE, 32'hFFFF_FFFF);
    readChk(A_FREE, 32'h0, "R9 unmapped read");
    readChk(A_LOAD, 32'h0, "R9 load offset reads zero");
    readChk(A_CTRL, EN_BOTH, "R9 unmapped write harmless");
    irqChk(1'b1, "R11 irq before reset");
    // reset in the middle of a run
    @(negedge clk); rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    readChk(A_CTRL, 32'h0, "R8 ctrl after reset");
    readChk(A_CMP1, 32'h0, "R8 cmp1 after reset");
    readChk(A_STAT, 32'h0, "R8 status after reset");
    irqChk(1'b0, "R8 irq after reset");
    wrReg(A_CTRL, EN_BOTH);
    readChk(A_CNT, 32'h0, "R8 count after reset");
    repeat (3) @(negedge clk);
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule